// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This unit watches a running calendar clock and raises an alarm when the current time matches a programmed alarm. The clock counters are kept elsewhere and arrive as BCD values for seconds, minutes, hours, day of week, day of month and month. A one-cycle tick marks the cycle in which those counters hold their new value for the current second. Only that cycle is considered for a match. The year is not part of the comparison.

Each of the six alarm fields is a byte register. Bits 6:0 hold a BCD value and bit 7 says whether that field takes part in the comparison. Software can therefore match on any subset of fields, for example "every hour at minute 45" or "day 1 of month 12". When every participating field equals its counter on a tick, a sticky alarm flag is set. The interrupt line is active while that flag and the interrupt enable are both set. Software clears the flag by writing zero to it through the same byte interface.

Top module: `cal_alarm_top`

## Requirements
- R1: After a synchronous active-low reset, all six alarm registers, the alarm flag and the interrupt enable read 0, and `irq_o` is low.
- R2: The alarm registers sit at host indices 8 (seconds), 9 (minutes), 10 (hours), 11 (day of week), 12 (day of month) and 13 (month). Each reads back the full byte written: bit 7 is the field's compare enable and bits 6:0 are the BCD value.
- R3: Host index 14 is the control byte. Bit 0 is the alarm flag and bit 3 is the interrupt enable. All other bits of this byte read 0.
- R4: A match is evaluated only in a cycle where `tick_i` is 1. The flag is visible from the clock edge that ends that cycle. Matching counters without a tick leave the flag unchanged.
- R5: A field whose bit 7 is 0 is a don't-care and matches any counter value, whatever its low bits hold.
- R6: If no field has bit 7 set, a tick never sets the flag.
- R7: The flag stays set until software writes control with bit 0 = 0. Writing bit 0 = 1 leaves the flag as it is. Software cannot set the flag. If a clearing write and a matching tick fall in the same cycle, the flag ends up set.
- R8: `irq_o` is 1 exactly when the flag and the interrupt enable are both 1. Setting the enable while the flag is already set raises `irq_o` at once.
- R9: The month field is compared directly against the 1..12 BCD month counter with no offset, so an alarm value of 0x12 matches counter 0x12.
- R10: A write to any index other than 8..14 changes no state, and a read from such an index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse: the counters hold this second's value |
| sec_i | input | 7 | Seconds counter, BCD |
| min_i | input | 7 | Minutes counter, BCD |
| hr_i | input | 7 | Hours counter, BCD |
| wday_i | input | 7 | Day-of-week counter, BCD |
| mday_i | input | 7 | Day-of-month counter, BCD |
| mon_i | input | 7 | Month counter, BCD 1..12 |
| host_wr | input | 1 | Byte write strobe |
| host_addr | input | 4 | Register index |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The assertions assume that `tick_i` is a single-cycle pulse and that the counter inputs are already stable in the cycle it is high. They also assume that a host write occupies exactly one cycle with a stable index and data. The bench follows these assumptions: it changes counters only on the falling edge before it raises the tick, drops the tick after one cycle, and issues each write as a one-cycle strobe. The one exception is the same-cycle set/clear check. That check deliberately overlaps a tick with a control write to exercise the priority rule.

// File: rtl/cal_alarm_pkg.sv
`timescale 1ns/1ps
// Shared layout constants for the calendar alarm match unit.
// Assumes one byte per alarm field and a single control byte.
package cal_alarm_pkg;
    localparam int NUM_FIELDS = 6;   // sec, min, hr, wday, mday, mon
    localparam int FIELD_W    = 7;   // BCD value width per field
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 4;
    localparam int ALARM_BASE = 8;   // first alarm index
    localparam int CTRL_IDX   = 14;  // control byte index
    localparam int FLAG_BIT   = 0;
    localparam int IE_BIT     = 3;
    localparam int EN_BIT     = FIELD_W; // per-field enable position
endpackage

// File: rtl/cal_alarm_fieldcmp.sv
`timescale 1ns/1ps
// One alarm field compare slice.
// Reports whether the field participates and whether it is satisfied.
// A field that does not participate is always satisfied.
// Assumes the counter value is already valid when it is sampled.
module cal_alarm_fieldcmp #(
    parameter int FIELD_W = 7
) (
    input  logic [FIELD_W:0]   alarm_byte,
    input  logic [FIELD_W-1:0] cnt_val,
    output logic               fld_en,
    output logic               fld_ok
);
    // Satisfied when disabled, or when the value equals the counter
    always_comb begin
        fld_en = alarm_byte[FIELD_W];
        fld_ok = !fld_en || (alarm_byte[FIELD_W-1:0] == cnt_val);
    end
endmodule

// File: rtl/cal_alarm_regs.sv
`timescale 1ns/1ps
// Alarm field register bank: one byte per field at consecutive indices.
// Assumes a single-cycle write strobe. Reset clears every field,
// which leaves all fields disabled.
module cal_alarm_regs #(
    parameter int NUM_FIELDS = 6,
    parameter int BYTE_W     = 8,
    parameter int ADDR_W     = 4,
    parameter int BASE       = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [BYTE_W-1:0]            wdata,
    output logic [NUM_FIELDS*BYTE_W-1:0] alarm_vec
);
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
        localparam logic [ADDR_W-1:0] MY_IDX = ADDR_W'(BASE + g);
        logic [BYTE_W-1:0] fld_q;
        // Capture a host write aimed at this field
        always_ff @(posedge clk) begin
            if (!rst_n)
                fld_q <= '0;
            else if (wr && addr == MY_IDX)
                fld_q <= wdata;
        end
        assign alarm_vec[g*BYTE_W +: BYTE_W] = fld_q;
    end
endmodule

// File: rtl/cal_alarm_ctrl.sv
`timescale 1ns/1ps
// Alarm flag and interrupt enable.
// The flag is set by a qualified match and cleared by a host write of 0
// to the flag bit. A match wins over a clear in the same cycle.
module cal_alarm_ctrl #(
    parameter int BYTE_W   = 8,
    parameter int FLAG_BIT = 0,
    parameter int IE_BIT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              match,
    output logic              flag_q,
    output logic              ie_q
);
    // Sticky alarm flag: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (match)
            flag_q <= 1'b1;
        else if (ctrl_wr && !wdata[FLAG_BIT])
            flag_q <= 1'b0;
    end

    // Interrupt enable follows every control write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ie_q <= 1'b0;
        else if (ctrl_wr)
            ie_q <= wdata[IE_BIT];
    end
endmodule

// File: rtl/cal_alarm_top.sv
`timescale 1ns/1ps
// Calendar alarm match unit, top level.
// Compares the BCD calendar counters with six alarm fields on each
// one-second tick. Any subset of fields may take part. A full match
// sets a sticky flag, and the interrupt is the flag gated by its enable.
// Assumes the counters are stable during the tick cycle.
module cal_alarm_top
    import cal_alarm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [FIELD_W-1:0] sec_i,
    input  logic [FIELD_W-1:0] min_i,
    input  logic [FIELD_W-1:0] hr_i,
    input  logic [FIELD_W-1:0] wday_i,
    input  logic [FIELD_W-1:0] mday_i,
    input  logic [FIELD_W-1:0] mon_i,
    input  logic               host_wr,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [BYTE_W-1:0]  host_wdata,
    output logic [BYTE_W-1:0]  host_rdata,
    output logic               irq_o
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_IDX);

    logic [NUM_FIELDS*BYTE_W-1:0]  alarm_vec;
    logic [NUM_FIELDS*FIELD_W-1:0] cnt_vec;
    logic [NUM_FIELDS-1:0]         fld_en;
    logic [NUM_FIELDS-1:0]         fld_ok;
    logic                          any_en;
    logic                          match;
    logic                          ctrl_wr;
    logic                          flag_q;
    logic                          ie_q;

    // Counters packed in field order, seconds at the low end
    assign cnt_vec = {mon_i, mday_i, wday_i, hr_i, min_i, sec_i};

    cal_alarm_regs #(
        .NUM_FIELDS(NUM_FIELDS), .BYTE_W(BYTE_W),
        .ADDR_W(ADDR_W), .BASE(ALARM_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(host_wr), .addr(host_addr),
        .wdata(host_wdata), .alarm_vec(alarm_vec)
    );

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
        cal_alarm_fieldcmp #(.FIELD_W(FIELD_W)) u_cmp (
            .alarm_byte(alarm_vec[g*BYTE_W +: BYTE_W]),
            .cnt_val(cnt_vec[g*FIELD_W +: FIELD_W]),
            .fld_en(fld_en[g]),
            .fld_ok(fld_ok[g])
        );
    end

    // Qualified match: on a tick, at least one field enabled, all satisfied
    always_comb begin
        any_en  = |fld_en;
        match   = tick_i && any_en && (&fld_ok);
        ctrl_wr = host_wr && (host_addr == CTRL_A);
    end

    cal_alarm_ctrl #(
        .BYTE_W(BYTE_W), .FLAG_BIT(FLAG_BIT), .IE_BIT(IE_BIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(host_wdata),
        .match(match), .flag_q(flag_q), .ie_q(ie_q)
    );

    // Interrupt output
    assign irq_o = flag_q && ie_q;

    // Read mux over alarm fields and control byte
    always_comb begin
        host_rdata = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (host_addr == ADDR_W'(ALARM_BASE + i))
                host_rdata = alarm_vec[i*BYTE_W +: BYTE_W];
        end
        if (host_addr == CTRL_A) begin
            host_rdata[FLAG_BIT] = flag_q;
            host_rdata[IE_BIT]   = ie_q;
        end
    end
endmodule

// File: rtl/cal_alarm_chk.sv
`timescale 1ns/1ps
// Protocol and behaviour checks for cal_alarm_top, bound to every instance.
module cal_alarm_chk
    import cal_alarm_pkg::*;
(
    input logic                         clk,
    input logic                         rst_n,
    input logic                         tick_i,
    input logic                         host_wr,
    input logic [ADDR_W-1:0]            host_addr,
    input logic [BYTE_W-1:0]            host_wdata,
    input logic [NUM_FIELDS*BYTE_W-1:0] alarm_vec,
    input logic                         flag_q,
    input logic                         ie_q,
    input logic                         irq_o
);
    logic none_en;
    logic ctrl_hit;
    always_comb begin
        none_en = 1'b1;
        for (int i = 0; i < NUM_FIELDS; i++)
            if (alarm_vec[i*BYTE_W + EN_BIT]) none_en = 1'b0;
        ctrl_hit = host_wr && host_addr == ADDR_W'(CTRL_IDX);
    end

    // R4
    flag_set_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick_i));

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && !host_wdata[FLAG_BIT] && !tick_i) |=> !flag_q);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !ctrl_hit) |=> flag_q);

    // R6
    no_field_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && none_en) |=> !flag_q);

    // R8
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_q || !flag_q) |-> !irq_o);

    // R10
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(alarm_vec) && $stable(ie_q));
endmodule

bind cal_alarm_top cal_alarm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .alarm_vec(alarm_vec),
    .flag_q(flag_q), .ie_q(ie_q), .irq_o(irq_o)
);

// File: tb/sim_cal_alarm_top.sv
`timescale 1ns/1ps
module sim_cal_alarm_top;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       tick_i = 0;
    logic [6:0] sec_i = 0, min_i = 0, hr_i = 0, wday_i = 0, mday_i = 0, mon_i = 0;
    logic       host_wr = 0;
    logic [3:0] host_addr = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic       irq_o;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cal_alarm_top u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .sec_i(sec_i), .min_i(min_i), .hr_i(hr_i), .wday_i(wday_i),
        .mday_i(mday_i), .mon_i(mon_i), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq_o(irq_o)
    );

    // alarm bytes {mon,mday,wday,hr,min,sec}, counters likewise, expected flag
    typedef struct packed {
        logic [47:0] alm;
        logic [41:0] cnt;
        logic        exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{alm: {8'h91,8'hA1,8'h83,8'h87,8'h95,8'hB0}, cnt: {7'h11,7'h21,7'h03,7'h07,7'h15,7'h30}, exp: 1'b1}, // R4 all fields
        '{alm: {8'h91,8'hA1,8'h83,8'h87,8'h95,8'hB0}, cnt: {7'h11,7'h21,7'h03,7'h07,7'h15,7'h31}, exp: 1'b0}, // R4 sec differs
        '{alm: {8'h00,8'h00,8'h00,8'h00,8'hC5,8'h00}, cnt: {7'h05,7'h17,7'h02,7'h22,7'h45,7'h09}, exp: 1'b1}, // R5 min only
        '{alm: {8'h00,8'h00,8'h00,8'h00,8'hC5,8'h00}, cnt: {7'h05,7'h17,7'h02,7'h22,7'h44,7'h09}, exp: 1'b0}, // R5 min differs
        '{alm: {8'h00,8'h00,8'h00,8'h00,8'h00,8'h00}, cnt: {7'h00,7'h00,7'h00,7'h00,7'h00,7'h00}, exp: 1'b0}, // R6 none enabled
        '{alm: {8'h92,8'h81,8'h00,8'h00,8'h00,8'h00}, cnt: {7'h12,7'h01,7'h04,7'h13,7'h27,7'h58}, exp: 1'b1}, // R9 month 12
        '{alm: {8'h92,8'h81,8'h00,8'h00,8'h00,8'h00}, cnt: {7'h11,7'h01,7'h04,7'h13,7'h27,7'h58}, exp: 1'b0}, // R9 month 11
        '{alm: {8'h00,8'h00,8'h86,8'hA3,8'h00,8'h00}, cnt: {7'h08,7'h30,7'h06,7'h23,7'h59,7'h59}, exp: 1'b1}, // R5 hr+wday
        '{alm: {8'h00,8'h00,8'h00,8'h00,8'h80,8'h30}, cnt: {7'h01,7'h01,7'h00,7'h00,7'h00,7'h59}, exp: 1'b1}  // R5 low bits ignored
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        host_addr = a;
        #1;
        chk(req, host_rdata, exp);
    endtask

    task automatic set_cnt(input logic [41:0] c);
        {mon_i, mday_i, wday_i, hr_i, min_i, sec_i} = c;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick_i = 1;
        @(negedge clk); tick_i = 0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        for (int a = 8; a <= 14; a++) rd_chk("R1", 4'(a), 8'h00);
        chk("R1 irq", {7'h0, irq_o}, 8'h00);

        // table walk
        for (int k = 0; k < NV; k++) begin
            wr_reg(4'd14, 8'h00);
            for (int f = 0; f < 6; f++) wr_reg(4'(8 + f), VECS[k].alm[f*8 +: 8]);
            @(negedge clk); set_cnt(VECS[k].cnt);
            pulse_tick();
            rd_chk($sformatf("R4/R5/R6/R9 vec%0d", k), 4'd14, {7'h0, VECS[k].exp});
            chk("R8 irq off", {7'h0, irq_o}, 8'h00);
        end

        // R2: readback and order
        wr_reg(4'd14, 8'h00);
        for (int f = 0; f < 6; f++) wr_reg(4'(8 + f), 8'(8'h10 + f));
        for (int f = 0; f < 6; f++) rd_chk("R2", 4'(8 + f), 8'(8'h10 + f));
        wr_reg(4'd13, 8'hFF); rd_chk("R2 bit7", 4'd13, 8'hFF);

        // R3/R7: control masks; software cannot set the flag
        wr_reg(4'd14, 8'hFF); rd_chk("R3 R7", 4'd14, 8'h08);
        wr_reg(4'd14, 8'h00); rd_chk("R3", 4'd14, 8'h00);

        // R4: matching counters without a tick
        wr_reg(4'd8, 8'h85); wr_reg(4'd9, 8'h00); wr_reg(4'd10, 8'h00);
        wr_reg(4'd11, 8'h00); wr_reg(4'd12, 8'h00); wr_reg(4'd13, 8'h00);
        @(negedge clk); set_cnt({7'h1, 7'h1, 7'h0, 7'h0, 7'h0, 7'h05});
        repeat (3) @(negedge clk);
        rd_chk("R4 no tick", 4'd14, 8'h00);
        pulse_tick();
        rd_chk("R4 tick", 4'd14, 8'h01);
        chk("R8 ie off", {7'h0, irq_o}, 8'h00);

        // R7/R8: keep flag while enabling irq
        wr_reg(4'd14, 8'h09);
        rd_chk("R7 keep", 4'd14, 8'h09);
        chk("R8 irq on", {7'h0, irq_o}, 8'h01);
        wr_reg(4'd14, 8'h08);
        rd_chk("R7 clear", 4'd14, 8'h08);
        chk("R8 irq drop", {7'h0, irq_o}, 8'h00);

        // R7: set wins over clear in the same cycle
        @(negedge clk);
        tick_i = 1; host_wr = 1; host_addr = 4'd14; host_wdata = 8'h08;
        @(negedge clk);
        tick_i = 0; host_wr = 0;
        rd_chk("R7 set wins", 4'd14, 8'h09);
        chk("R8 irq", {7'h0, irq_o}, 8'h01);

        // R10: writes to other indices ignored
        wr_reg(4'd5, 8'hFF); wr_reg(4'd15, 8'h00); wr_reg(4'd0, 8'hAA);
        rd_chk("R10 rd", 4'd5, 8'h00);
        rd_chk("R10 rd", 4'd15, 8'h00);
        rd_chk("R10 ctrl", 4'd14, 8'h09);
        rd_chk("R10 fld", 4'd8, 8'h85);
        rd_chk("R10 fld", 4'd13, 8'h00);

        done = 1;
        summary();
    end
endmodule